// File: doc/BRIEF.md
# Store Data Lane Queue

This block decouples an integer pipeline from a 32-bit memory write bus. The pipeline hands over a store as raw source data, the two low address bits and a data-type code, and moves on at once. The entry waits in a small FIFO. When the memory side asks for data, the block presents the oldest entry already steered onto the correct byte or half-word lane, together with its 4-bit byte enables. The same pop removes that entry.

Narrow signed stores are range-checked as they enter the queue. A value that does not fit gives a one-cycle error pulse, and the truncated value is still queued. A store flagged as coming from the status register writes zero. A double-word store becomes two consecutive entries.

Data-type codes on `in_kind`:

| Code | Type |
|------|------|
| 0 | unsigned byte |
| 1 | signed byte |
| 2 | unsigned half-word |
| 3 | signed half-word |
| 4 | word |
| 5 | double-word |

Codes 6 and 7 behave as word.

Top module: `store_lane_queue`

## Requirements
- R1: After reset the block shows `out_valid`=0, `full`=0, `in_ready`=1, `range_err`=0, `out_be`=0 and `out_data`=0.
- R2: A word entry (code 4) and each word of a double-word entry (code 5) appear on `out_data` unchanged, with `out_be`=4'b1111.
- R3: A byte entry (codes 0 and 1) places source bits [7:0] at bit position 8*addr and sets only `out_be[addr]`. All other data bits are zero.
- R4: A half-word entry (codes 2 and 3) places source bits [15:0] at bit position 16*addr[1] and sets only the two enables of that half (addr[1]=0 gives 4'b0011, addr[1]=1 gives 4'b1100). All other data bits are zero.
- R5: `range_err` is high for exactly the one cycle after a store is accepted when either of these holds: code 1 with source bits [31:7] not all equal, or code 3 with source bits [31:15] not all equal. It never rises for any other code.
- R6: A signed store that raises a range error is still queued, and it is driven with its truncated low byte or low half-word.
- R7: When `in_from_sr` is 1 at acceptance, the stored value is zero for the single word and for both words of a double-word store. Such a store never raises a range error.
- R8: An accepted double-word store enqueues `in_data` first and `in_data_hi` second. Both entries carry the same address bits and type code.
- R9: Entries leave in strict acceptance order. The head is removed only on a cycle with `out_pop`=1 and `out_valid`=1. A pop while the queue is empty has no effect. The head stays stable while it is not popped.
- R10: `in_ready` is 1 exactly when at least two slots are free, whatever the pending type. `full` is 1 exactly when all DEPTH slots (default 4) are occupied.
- R11: An enqueue and a dequeue in the same cycle both take effect: the head leaves and the new entry or entries join the tail.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Store request present |
| in_ready | output | 1 | At least two free slots; the request is accepted when in_valid is also high |
| in_kind | input | 3 | Data-type code |
| in_addr | input | 2 | Memory address bits [1:0] |
| in_data | input | 32 | Source word (first word of a double-word) |
| in_data_hi | input | 32 | Second source word of a double-word |
| in_from_sr | input | 1 | Source is the status register; store zero |
| range_err | output | 1 | One-cycle signed range error pulse |
| full | output | 1 | All slots occupied |
| out_pop | input | 1 | Memory side consumes the head entry |
| out_valid | output | 1 | Head entry present |
| out_data | output | 32 | Lane-steered head data |
| out_be | output | 4 | Byte write enables of the head |

## Verification
Acceptance of a new store and removal of the head by the memory side can fall in the same clock. In that cycle the pointers and the count move together, and a double-word may add two entries while one leaves. The bench provokes this with directed bursts that hold the queue at its ready threshold while popping. It also runs a long random stretch in which `in_valid` and `out_pop` toggle independently. A behavioural queue model in the bench applies the pop, then the push, on each edge. Every clock it compares readiness, fullness, the head's lanes and enables, and the error pulse against that model.

// File: rtl/store_lane_queue.sv
module store_lane_queue #(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [2:0]  in_kind,
  input  logic [1:0]  in_addr,
  input  logic [31:0] in_data,
  input  logic [31:0] in_data_hi,
  input  logic        in_from_sr,
  output logic        range_err,
  output logic        full,
  input  logic        out_pop,
  output logic        out_valid,
  output logic [31:0] out_data,
  output logic [3:0]  out_be
);
  localparam int PW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;
  localparam logic [2:0] K_UB = 3'd0, K_SB = 3'd1, K_UH = 3'd2, K_SH = 3'd3, K_DW = 3'd5;

  logic [31:0]   slot_data [DEPTH];
  logic [1:0]    slot_addr [DEPTH];
  logic [2:0]    slot_kind [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  wire           accept  = in_valid && in_ready;
  wire           is_pair = in_kind == K_DW;
  wire           take    = out_pop && out_valid;
  wire [31:0]    src_lo  = in_from_sr ? 32'd0 : in_data;
  wire [31:0]    src_hi  = in_from_sr ? 32'd0 : in_data_hi;
  wire           sb_bad  = !((&src_lo[31:7]) || !(|src_lo[31:7]));
  wire           sh_bad  = !((&src_lo[31:15]) || !(|src_lo[31:15]));
  wire           bad     = (in_kind == K_SB && sb_bad) || (in_kind == K_SH && sh_bad);
  wire [PW-1:0]  wr_next = wr_ptr + 1'b1;
  wire [CW-1:0]  n_push  = accept ? (is_pair ? CW'(2) : CW'(1)) : CW'(0);
  wire [CW-1:0]  n_pop   = take ? CW'(1) : CW'(0);

  assign in_ready  = count <= CW'(DEPTH - 2);
  assign full      = count == CW'(DEPTH);
  assign out_valid = count != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      range_err <= 1'b0;
    end else begin
      range_err <= accept && bad;
      count     <= count + n_push - n_pop;
      if (take) rd_ptr <= rd_ptr + 1'b1;
      if (accept) wr_ptr <= is_pair ? wr_ptr + PW'(2) : wr_next;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      slot_data[wr_ptr] <= src_lo;
      slot_addr[wr_ptr] <= in_addr;
      slot_kind[wr_ptr] <= in_kind;
      if (is_pair) begin
        slot_data[wr_next] <= src_hi;
        slot_addr[wr_next] <= in_addr;
        slot_kind[wr_next] <= in_kind;
      end
    end
  end

  wire [31:0] h_data = slot_data[rd_ptr];
  wire [1:0]  h_addr = slot_addr[rd_ptr];
  wire [2:0]  h_kind = slot_kind[rd_ptr];

  always_comb begin
    out_data = 32'd0;
    out_be   = 4'd0;
    if (out_valid) begin
      case (h_kind)
        K_UB, K_SB: begin
          out_data = {24'd0, h_data[7:0]} << {h_addr, 3'b000};
          out_be   = 4'b0001 << h_addr;
        end
        K_UH, K_SH: begin
          out_data = {16'd0, h_data[15:0]} << {h_addr[1], 4'b0000};
          out_be   = h_addr[1] ? 4'b1100 : 4'b0011;
        end
        default: begin
          out_data = h_data;
          out_be   = 4'b1111;
        end
      endcase
    end
  end
endmodule

// File: rtl/store_lane_queue_chk.sv
module store_lane_queue_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [2:0]  in_kind,
  input logic        full,
  input logic        range_err,
  input logic        out_valid,
  input logic        out_pop,
  input logic [31:0] out_data,
  input logic [3:0]  out_be
);
  p_full_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !in_ready);

  p_be_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_be) == 1 || out_be == 4'b0011 ||
                   out_be == 4'b1100 || out_be == 4'b1111));

  p_unsigned_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_kind != 3'd1 && in_kind != 3'd3) |=> !range_err);

  p_err_follows_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> $past(in_valid && in_ready));

  p_head_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_pop) |=> (out_valid && $stable(out_data) && $stable(out_be)));

  p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !in_valid) |=> !out_valid);
endmodule

bind store_lane_queue store_lane_queue_chk u_chk (.*);

// File: tb/store_lane_queue_tb.sv
module store_lane_queue_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_from_sr = 0, out_pop = 0;
  logic [2:0] in_kind = 0;
  logic [1:0] in_addr = 0;
  logic [31:0] in_data = 0, in_data_hi = 0;
  logic in_ready, range_err, full, out_valid;
  logic [31:0] out_data;
  logic [3:0] out_be;

  int n_cmp = 0, n_bad = 0;
  logic [36:0] mq[$];
  bit exp_err = 0;
  string phase = "R1 reset";

  always #(CLK_PERIOD/2) clk = ~clk;

  store_lane_queue #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_addr(in_addr), .in_data(in_data), .in_data_hi(in_data_hi),
    .in_from_sr(in_from_sr), .range_err(range_err), .full(full),
    .out_pop(out_pop), .out_valid(out_valid), .out_data(out_data), .out_be(out_be));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (%s): actual %h expected %h", req, phase, act, exp);
    end
  endtask

  task automatic compare();
    logic [31:0] ed;
    logic [3:0] eb;
    string tag;
    ed = 0; eb = 0; tag = "R2";
    if (mq.size() > 0) begin
      logic [31:0] d;
      logic [1:0] a;
      logic [2:0] k;
      {k, a, d} = mq[0];
      if (k <= 3'd1) begin
        tag = "R3";
        ed = 32'(d[7:0]) << (8 * a);
        eb = 4'(1 << a);
      end else if (k <= 3'd3) begin
        tag = "R4";
        ed = 32'(d[15:0]) << (16 * a[1]);
        eb = 4'(3 << (2 * a[1]));
      end else begin
        ed = d;
        eb = 4'hf;
      end
    end
    chk("R10 in_ready", 32'(in_ready), 32'(mq.size() <= DEPTH - 2));
    chk("R10 full", 32'(full), 32'(mq.size() == DEPTH));
    chk("R9 out_valid", 32'(out_valid), 32'(mq.size() > 0));
    chk("R5 range_err", 32'(range_err), 32'(exp_err));
    chk({tag, " out_data"}, out_data, ed);
    chk({tag, " out_be"}, 32'(out_be), 32'(eb));
  endtask

  task automatic step(input bit v, input logic [2:0] k, input logic [1:0] a,
                      input logic [31:0] d, input logic [31:0] dh, input bit sr, input bit pp);
    bit acc, tk, bad;
    logic [31:0] lo, hi;
    int signed sv;
    @(negedge clk);
    compare();
    in_valid = v; in_kind = k; in_addr = a; in_data = d; in_data_hi = dh;
    in_from_sr = sr; out_pop = pp;
    acc = v && (mq.size() <= DEPTH - 2);
    tk = pp && (mq.size() > 0);
    lo = sr ? 32'd0 : d;
    hi = sr ? 32'd0 : dh;
    sv = lo;
    bad = (k == 3'd1 && (sv < -128 || sv > 127)) || (k == 3'd3 && (sv < -32768 || sv > 32767));
    @(posedge clk);
    if (tk) void'(mq.pop_front());
    if (acc) begin
      mq.push_back({k, a, lo});
      if (k == 3'd5) mq.push_back({k, a, hi});
    end
    exp_err = acc && bad;
  endtask

  task automatic idle(input int n, input bit pp);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, pp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare();  // R1 reset state
    rst_n = 1;
    idle(1, 0);

    phase = "R3 byte lanes";
    for (int a = 0; a < 4; a++) begin
      step(1, 3'd0, 2'(a), 32'hdead_be00 | 32'(a + 8'h51), 0, 0, 0);
      idle(2, 1);
    end
    phase = "R4 half lanes";
    for (int a = 0; a < 4; a++) begin
      step(1, 3'd2, 2'(a), 32'h1234_a5c3 + 32'(a), 0, 0, 0);
      idle(2, 1);
    end
    phase = "R2 word";
    step(1, 3'd4, 2'd2, 32'hcafe_f00d, 0, 0, 0);
    idle(2, 1);

    phase = "R5 R6 signed range";
    step(1, 3'd1, 2'd1, 32'h0000_0080, 0, 0, 0);
    step(1, 3'd1, 2'd3, 32'hffff_ff80, 0, 0, 1);
    step(1, 3'd3, 2'd2, 32'h0001_7fff, 0, 0, 1);
    step(1, 3'd3, 2'd0, 32'hffff_8000, 0, 0, 1);
    step(1, 3'd3, 2'd0, 32'h7fff_0000, 0, 0, 1);
    step(1, 3'd0, 2'd0, 32'hffff_ff00, 0, 0, 1);
    idle(3, 1);

    phase = "R7 status register zero";
    step(1, 3'd1, 2'd0, 32'h8000_0000, 0, 1, 0);
    step(1, 3'd5, 2'd0, 32'h1111_1111, 32'h2222_2222, 1, 1);
    idle(4, 1);

    phase = "R8 double-word order";
    step(1, 3'd5, 2'd1, 32'haaaa_0001, 32'hbbbb_0002, 0, 0);
    idle(1, 0);
    idle(3, 1);

    phase = "R10 fill and refuse";
    step(1, 3'd4, 0, 32'h1, 0, 0, 0);
    step(1, 3'd4, 0, 32'h2, 0, 0, 0);
    step(1, 3'd4, 0, 32'h3, 0, 0, 0);
    step(1, 3'd5, 0, 32'h4, 32'h5, 0, 0);
    step(1, 3'd0, 0, 32'h6, 0, 0, 0);
    step(1, 3'd0, 0, 32'h7, 0, 0, 0);
    idle(2, 0);

    phase = "R11 simultaneous enqueue and dequeue";
    step(1, 3'd4, 0, 32'h10, 0, 0, 1);
    step(1, 3'd5, 0, 32'h11, 32'h12, 0, 1);
    step(1, 3'd4, 0, 32'h13, 0, 0, 1);
    step(1, 3'd2, 2'd2, 32'h14, 0, 0, 1);
    idle(5, 1);

    phase = "R9 pop while empty";
    idle(3, 1);
    step(1, 3'd4, 0, 32'h99, 0, 0, 1);
    idle(2, 0);
    idle(2, 1);

    phase = "R11 R9 random traffic";
    for (int i = 0; i < 600; i++)
      step(1'($urandom_range(0, 2) != 0), 3'($urandom_range(0, 5)), 2'($urandom),
           ($urandom_range(0, 1) != 0) ? 32'($signed(16'($urandom))) : 32'($urandom),
           32'($urandom), $urandom_range(0, 15) == 0, 1'($urandom_range(0, 2) != 0));
    idle(6, 1);
    @(negedge clk);
    compare();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule